// File: doc/BRIEF.md
# Programmable Tuner Divider with Reference Select and Phase Comparator

This block is the digital core of a tuner frequency synthesizer. A reference divider turns a fixed reference clock into one of seven comparison rates. A programmable main divider takes one of two RF paths and divides it down to the same rate. A phase-frequency detector compares the two divided signals and drives pump-up and pump-down requests toward an external charge pump. The control fields arrive already parsed: a 16-bit division word, a 3-bit reference code, a path bit and a swallow-enable bit.

All logic runs on one system clock. The reference clock and both RF inputs are presented as one-cycle tick strobes, one strobe per input edge. The prescaled path passes through a fixed binary prescaler before the main divider. On the direct path the word is either a plain divide ratio or, in swallow mode, a dual-modulus 32/33 count. A new word, reference code or path choice takes effect at the next terminal count, so no divided period is ever cut short.

Top module: `tsyn_divider_core`

## Requirements
- R1: During and straight after reset, `pump_up`, `pump_dn`, `ref_pulse` and `vco_pulse` are all 0.
- R2: With `ref_sel` codes 0,1,2,3,4,5,6 the reference divider emits one `ref_pulse` every 180, 360, 720, 450, 500, 900 and 4500 `ref_tick` strobes respectively (the reference rate divided by 25, 12.5, 6.25, 10, 9, 5 and 1 kHz). The pulse appears one cycle after the tick that completes the period.
- R3: `ref_sel` = 7 holds the reference divider in reset, and no `ref_pulse` appears. Once a code 0..6 returns, the first pulse follows after exactly one full period of ticks, counted from the cycle after the code change.
- R4: With `path_am` = 0 the main divider counts `fm_tick` through a divide-by-16 prescaler, and it emits one `vco_pulse` per 16 × `div_word[15:4]` ticks. Bits `div_word[3:0]` have no effect.
- R5: With `path_am` = 1 and `swallow_en` = 0, one `vco_pulse` is emitted per `div_word` `am_tick` strobes. The pulse appears one cycle after the completing tick.
- R6: With `path_am` = 1 and `swallow_en` = 1, the word splits into a main count M = `div_word[15:5]` and a swallow count A = `div_word[4:0]`. The period is 33·A + 32·(M−A) = 32·M + A ticks, for 1 ≤ M and A ≤ M.
- R7: `swallow_en` has no effect while `path_am` = 0.
- R8: A change of `div_word` during a period does not alter that period. The new value governs the period that starts at the next terminal count.
- R9: When the reference pulse leads, `pump_up` rises one cycle after the reference pulse and stays high until one cycle after the divided-VCO pulse. It is therefore high for 4 cycles per comparison when the edges are 4 cycles apart.
- R10: When the divided-VCO pulse leads, `pump_dn` behaves in the same way as R9 with the roles exchanged.
- R11: Coincident reference and divided-VCO pulses produce no pump output, and `pump_up` and `pump_dn` are never high together.
- R12: On the direct path a division value of 0 or 1 yields one `vco_pulse` per `am_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the counters from the control fields |
| ref_tick | input | 1 | One-cycle strobe per reference clock edge |
| fm_tick | input | 1 | One-cycle strobe per edge of the prescaled RF path |
| am_tick | input | 1 | One-cycle strobe per edge of the direct RF path |
| div_word | input | 16 | Division value |
| ref_sel | input | 3 | Comparison rate code, 7 = reference divider held |
| path_am | input | 1 | 0 = prescaled path, 1 = direct path |
| swallow_en | input | 1 | Dual-modulus enable, direct path only |
| ref_pulse | output | 1 | One-cycle divided reference pulse |
| vco_pulse | output | 1 | One-cycle divided VCO pulse |
| pump_up | output | 1 | Phase detector raise request |
| pump_dn | output | 1 | Phase detector lower request |

## Verification
The bench builds the block with its default parameters: a 4.5 MHz reference, a divide-by-16 prescaler, a 16-bit word and a 5-bit swallow field. With these values every one of the seven reference ratios, up to the 4500-tick period, can be measured period by period. Small division words keep the prescaled and swallow periods short enough to measure many random words. Equal reference and direct ratios of 180 let the bench align the two dividers and then shift them by one tick, which places exact pump-pulse widths within reach.

// File: rtl/tsyn_pkg.sv
// Shared types and helpers for the tuner divider core.
// Assumes the comparison-rate table below is the only one in use.
package tsyn_pkg;

    typedef enum logic [1:0] {
        MODE_PRESCALED = 2'd0,
        MODE_DIRECT    = 2'd1,
        MODE_SWALLOW   = 2'd2
    } div_mode_e;

    localparam int unsigned NUM_REF_CODES = 7;
    localparam logic [2:0]  REF_CODE_OFF  = 3'd7;

    // Comparison frequency in Hz for a reference code.
    function automatic int unsigned comp_freq_hz(input logic [2:0] code);
        case (code)
            3'd0:    return 25000;
            3'd1:    return 12500;
            3'd2:    return 6250;
            3'd3:    return 10000;
            3'd4:    return 9000;
            3'd5:    return 5000;
            default: return 1000;
        endcase
    endfunction

    // Divider mode from path and swallow bits; swallow needs the direct path.
    function automatic div_mode_e pick_mode(input logic am, input logic swl);
        if (!am)
            return MODE_PRESCALED;
        else if (swl)
            return MODE_SWALLOW;
        else
            return MODE_DIRECT;
    endfunction

endpackage

// File: rtl/tsyn_ref_div.sv
// Reference divider: counts reference ticks and emits one pulse per period.
// The ratio is REF_HZ divided by the selected comparison rate. Code 7 holds
// the counter. A new code is taken at the terminal count only.
// Assumes REF_HZ is a multiple of every table rate.
module tsyn_ref_div
    import tsyn_pkg::*;
#(
    parameter int unsigned REF_HZ = 4_500_000,
    parameter int unsigned CNT_W  = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [2:0] sel,
    output logic       pulse
);

    logic [CNT_W-1:0] ratio_tab [8];
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_q;
    logic             idle_q;
    logic             pulse_q;
    logic             sel_off;

    // Build the reload table at elaboration, one entry per code.
    for (genvar g = 0; g < 8; g++) begin : g_tab
        if (g < NUM_REF_CODES) begin : g_on
            assign ratio_tab[g] = CNT_W'(REF_HZ / comp_freq_hz(3'(g)) - 1);
        end else begin : g_off
            assign ratio_tab[g] = '0;
        end
    end

    // Select the reload value for the present code.
    always_comb begin
        sel_off  = (sel == REF_CODE_OFF);
        load_val = ratio_tab[sel];
    end

    // Down-counter with reload at terminal count and hold on code 7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q  <= sel_off;
            cnt_q   <= sel_off ? '0 : load_val;
            pulse_q <= 1'b0;
        end else if (sel_off) begin
            idle_q  <= 1'b1;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (idle_q) begin
            idle_q  <= 1'b0;
            cnt_q   <= load_val;
            pulse_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q == '0) begin
                cnt_q   <= load_val;
                pulse_q <= 1'b1;
            end else begin
                cnt_q   <= cnt_q - 1'b1;
                pulse_q <= 1'b0;
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign pulse = pulse_q;

    assert_pulse_needs_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> $past(tick));

    assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_off |=> !pulse_q);

endmodule

// File: rtl/tsyn_prescaler.sv
// Fixed prescaler: one output pulse per DIV input ticks, registered.
// Assumes DIV is at least 2.
module tsyn_prescaler #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic pulse
);

    localparam int unsigned W = $clog2(DIV);

    logic [W-1:0] cnt_q;
    logic         pulse_q;

    // Wrap counter on ticks; pulse on the tick that completes DIV.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else if (tick) begin
            if (cnt_q == W'(DIV - 1)) begin
                cnt_q   <= '0;
                pulse_q <= 1'b1;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                pulse_q <= 1'b0;
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign pulse = pulse_q;

    assert_pre_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

endmodule

// File: rtl/tsyn_main_div.sv
// Main programmable divider with three modes: the upper word bits after the
// prescaler, the full word as a direct ratio, or a dual-modulus count
// (modulus 2**SWL_W / 2**SWL_W+1) with main count M and swallow count A.
// Word, mode and source are sampled at the terminal count and at reset only.
// Assumes in swallow mode that 1 <= M and A <= M.
module tsyn_main_div
    import tsyn_pkg::*;
#(
    parameter int unsigned DIV_W = 16,
    parameter int unsigned PRE_W = 4,
    parameter int unsigned SWL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick,
    input  logic             am_tick,
    input  logic [DIV_W-1:0] div_word,
    input  logic             path_am,
    input  logic             swallow_en,
    output logic             pulse
);

    localparam int unsigned MAIN_W = DIV_W - SWL_W;
    localparam int unsigned MOD_W  = SWL_W + 1;
    localparam logic [MOD_W-1:0] MOD_HI_LOAD = MOD_W'(2 ** SWL_W);
    localparam logic [MOD_W-1:0] MOD_LO_LOAD = MOD_W'(2 ** SWL_W - 1);

    div_mode_e          mode_n, mode_q;
    logic [DIV_W-1:0]   ratio_n;
    logic [DIV_W-1:0]   cnt_load;
    logic [MAIN_W-1:0]  m_n;
    logic [SWL_W-1:0]   a_n;
    logic [MOD_W-1:0]   p_load;
    logic [DIV_W-1:0]   cnt_q;
    logic [SWL_W-1:0]   swl_q;
    logic [MOD_W-1:0]   pcnt_q;
    logic               pulse_q;
    logic               src_tick;

    // Reload values from the live control fields.
    always_comb begin
        mode_n  = pick_mode(path_am, swallow_en);
        ratio_n = (mode_n == MODE_PRESCALED)
                ? {{PRE_W{1'b0}}, div_word[DIV_W-1:PRE_W]} : div_word;
        m_n     = div_word[DIV_W-1:SWL_W];
        a_n     = div_word[SWL_W-1:0];
        p_load  = (a_n != '0) ? MOD_HI_LOAD : MOD_LO_LOAD;
        if (mode_n == MODE_SWALLOW)
            cnt_load = (m_n == '0) ? '0 : DIV_W'(m_n - 1'b1);
        else
            cnt_load = (ratio_n == '0) ? '0 : ratio_n - 1'b1;
    end

    // Count source follows the mode latched for the running period.
    always_comb src_tick = (mode_q == MODE_PRESCALED) ? pre_tick : am_tick;

    // Period counter with dual-modulus inner count in swallow mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= mode_n;
            cnt_q   <= cnt_load;
            swl_q   <= a_n;
            pcnt_q  <= p_load;
            pulse_q <= 1'b0;
        end else if (src_tick) begin
            if (mode_q != MODE_SWALLOW) begin
                if (cnt_q == '0) begin
                    mode_q  <= mode_n;
                    cnt_q   <= cnt_load;
                    swl_q   <= a_n;
                    pcnt_q  <= p_load;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q   <= cnt_q - 1'b1;
                    pulse_q <= 1'b0;
                end
            end else if (pcnt_q != '0) begin
                pcnt_q  <= pcnt_q - 1'b1;
                pulse_q <= 1'b0;
            end else if (cnt_q == '0) begin
                mode_q  <= mode_n;
                cnt_q   <= cnt_load;
                swl_q   <= a_n;
                pcnt_q  <= p_load;
                pulse_q <= 1'b1;
            end else begin
                cnt_q   <= cnt_q - 1'b1;
                swl_q   <= swl_q - SWL_W'(swl_q != '0);
                pcnt_q  <= (swl_q > SWL_W'(1)) ? MOD_HI_LOAD : MOD_LO_LOAD;
                pulse_q <= 1'b0;
            end
        end else begin
            pulse_q <= 1'b0;
        end
    end

    assign pulse = pulse_q;

    assert_pulse_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> ($past(pre_tick) || $past(am_tick)));

    assert_swallow_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SWALLOW) |-> (pcnt_q <= MOD_HI_LOAD));

endmodule

// File: rtl/tsyn_pfd.sv
// Phase-frequency detector on one-cycle pulses. A reference pulse sets the
// up request and a divided-VCO pulse sets the down request. Once both have
// arrived, both clear. Coincident pulses cancel.
module tsyn_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_p,
    input  logic vco_p,
    output logic up,
    output logic dn
);

    logic up_q, dn_q, up_n, dn_n;

    // Next request state with mutual clear.
    always_comb begin
        up_n = up_q | ref_p;
        dn_n = dn_q | vco_p;
        if (up_n && dn_n) begin
            up_n = 1'b0;
            dn_n = 1'b0;
        end
    end

    // Request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_n;
            dn_q <= dn_n;
        end
    end

    assign up = up_q;
    assign dn = dn_q;

    assert_never_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_q && dn_q));

    assert_up_on_lead_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_p && !vco_p && !dn_q) |=> up_q);

    assert_dn_on_lead_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vco_p && !ref_p && !up_q) |=> dn_q);

endmodule

// File: rtl/tsyn_divider_core.sv
// Top of the tuner divider core: reference divider, prescaler, main divider
// and phase detector on one clock. RF and reference edges enter as strobes.
module tsyn_divider_core #(
    parameter int unsigned REF_HZ  = 4_500_000,
    parameter int unsigned PRE_DIV = 16,
    parameter int unsigned DIV_W   = 16,
    parameter int unsigned SWL_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             fm_tick,
    input  logic             am_tick,
    input  logic [DIV_W-1:0] div_word,
    input  logic [2:0]       ref_sel,
    input  logic             path_am,
    input  logic             swallow_en,
    output logic             ref_pulse,
    output logic             vco_pulse,
    output logic             pump_up,
    output logic             pump_dn
);

    localparam int unsigned REF_CNT_W = $clog2(REF_HZ / 1000);
    localparam int unsigned PRE_W     = $clog2(PRE_DIV);

    logic pre_pulse;

    tsyn_ref_div #(.REF_HZ(REF_HZ), .CNT_W(REF_CNT_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .tick(ref_tick), .sel(ref_sel), .pulse(ref_pulse)
    );

    tsyn_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(fm_tick), .pulse(pre_pulse)
    );

    tsyn_main_div #(.DIV_W(DIV_W), .PRE_W(PRE_W), .SWL_W(SWL_W)) u_main (
        .clk(clk), .rst_n(rst_n), .pre_tick(pre_pulse), .am_tick(am_tick),
        .div_word(div_word), .path_am(path_am), .swallow_en(swallow_en),
        .pulse(vco_pulse)
    );

    tsyn_pfd u_pfd (
        .clk(clk), .rst_n(rst_n), .ref_p(ref_pulse), .vco_p(vco_pulse),
        .up(pump_up), .dn(pump_dn)
    );

endmodule

// File: tb/tsyn_divider_core_tb.sv
module tsyn_divider_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0, fm_tick = 1'b0, am_tick = 1'b0;
    logic [15:0] div_word = 16'd180;
    logic [2:0]  ref_sel = 3'd0;
    logic        path_am = 1'b1, swallow_en = 1'b0;
    logic        ref_pulse, vco_pulse, pump_up, pump_dn;

    int checks = 0, errors = 0, cycles = 0;
    int ref_ticks = 0, vco_ticks = 0, ref_prev = 0, vco_prev = 0;
    int ref_iv = 0, vco_iv = 0, ref_np = 0, vco_np = 0;
    int up_cyc = 0, dn_cyc = 0, both_cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tsyn_divider_core u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fm_tick(fm_tick),
        .am_tick(am_tick), .div_word(div_word), .ref_sel(ref_sel),
        .path_am(path_am), .swallow_en(swallow_en), .ref_pulse(ref_pulse),
        .vco_pulse(vco_pulse), .pump_up(pump_up), .pump_dn(pump_dn)
    );

    function automatic int exp_ref(input int code);
        int f;
        case (code)
            0: f = 25000; 1: f = 12500; 2: f = 6250; 3: f = 10000;
            4: f = 9000;  5: f = 5000;  default: f = 1000;
        endcase
        return 4500000 / f;
    endfunction

    function automatic int exp_main(input logic [15:0] w, input bit am, input bit ps);
        int r;
        if (!am) r = 16 * int'(w[15:4]);
        else if (!ps) r = (w < 2) ? 1 : int'(w);
        else r = 32 * int'(w[15:5]) + int'(w[4:0]);
        return r;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // Pulse and pump monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (ref_pulse) begin ref_iv = ref_ticks - ref_prev; ref_prev = ref_ticks; ref_np++; end
            if (vco_pulse) begin vco_iv = vco_ticks - vco_prev; vco_prev = vco_ticks; vco_np++; end
            if (pump_up) up_cyc++;
            if (pump_dn) dn_cyc++;
            if (pump_up && pump_dn) both_cyc++;
        end
        if (cycles > 190000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog got %0d expected below 190000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic reset_dut();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        ref_ticks = 0; vco_ticks = 0; ref_prev = 0; vco_prev = 0;
        ref_np = 0; vco_np = 0; up_cyc = 0; dn_cyc = 0; both_cyc = 0;
        rst_n = 1'b1;
    endtask

    task automatic step(input bit r, input bit v);
        @(negedge clk);
        ref_tick = r;
        if (path_am) am_tick = v; else fm_tick = v;
        if (r) ref_ticks++;
        if (v) vco_ticks++;
        @(negedge clk);
        ref_tick = 1'b0; fm_tick = 1'b0; am_tick = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_ref(input string req);
        int n0 = ref_np;
        int s = 0;
        while (ref_np == n0 && s < 6000) begin step(1, 0); s++; end
        if (ref_np == n0) chk(req, 0, 1);
    endtask

    task automatic run_vco(input string req);
        int n0 = vco_np;
        int s = 0;
        while (vco_np == n0 && s < 6000) begin step(0, 1); s++; end
        if (vco_np == n0) chk(req, 0, 1);
    endtask

    task automatic measure_vco(input string req, input logic [15:0] w);
        div_word = w;
        run_vco(req);
        run_vco(req);
        chk(req, vco_iv, exp_main(w, path_am, swallow_en));
    endtask

    initial begin
        logic [15:0] w;
        int m, a, n0;
        void'($urandom(32'd2024));

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset up", int'(pump_up), 0);
        chk("R1 reset dn", int'(pump_dn), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ref_pulse", int'(ref_pulse), 0);
        chk("R1 vco_pulse", int'(vco_pulse), 0);

        // R2: every reference code
        ref_sel = 3'd0;
        reset_dut();
        for (int c = 0; c < 7; c++) begin
            ref_sel = 3'(c);
            run_ref("R2");
            run_ref("R2");
            chk($sformatf("R2 code %0d", c), ref_iv, exp_ref(c));
        end

        // R3: code 7 holds, restart gives a whole period
        ref_sel = 3'd7;
        repeat (2) @(negedge clk);
        n0 = ref_np;
        repeat (300) step(1, 0);
        chk("R3 no pulse while held", ref_np - n0, 0);
        ref_sel = 3'd0;
        repeat (2) @(negedge clk);
        ref_prev = ref_ticks;
        run_ref("R3");
        chk("R3 first period after hold", ref_iv, 180);

        // R4: prescaled path, low bits ignored
        path_am = 1'b0; swallow_en = 1'b0; div_word = 16'h0053;
        reset_dut();
        run_vco("R4");
        chk("R4 period from reset", vco_iv, 80);
        measure_vco("R4 low bits ignored", 16'h005C);
        measure_vco("R4 ratio 18", 16'h0127);
        // R7: swallow bit without effect on prescaled path
        swallow_en = 1'b1;
        measure_vco("R7 swallow ignored", 16'h005A);
        swallow_en = 1'b0;

        // R5: direct ratio, directed then random
        path_am = 1'b1; div_word = 16'd37;
        reset_dut();
        run_vco("R5");
        chk("R5 period from reset", vco_iv, 37);
        for (int i = 0; i < 4; i++) begin
            w = 16'($urandom_range(2, 300));
            measure_vco("R5 random", w);
        end

        // R6: swallow mode, directed then random
        swallow_en = 1'b1;
        measure_vco("R6 M3 A2", {11'd3, 5'd2});
        measure_vco("R6 M2 A0", {11'd2, 5'd0});
        measure_vco("R6 M4 A4", {11'd4, 5'd4});
        for (int i = 0; i < 3; i++) begin
            m = int'($urandom_range(1, 8));
            a = int'($urandom_range(0, m));
            measure_vco("R6 random", {11'(m), 5'(a)});
        end
        swallow_en = 1'b0;

        // R8: word change mid-period
        div_word = 16'd50;
        reset_dut();
        repeat (20) step(0, 1);
        div_word = 16'd90;
        run_vco("R8");
        chk("R8 running period kept", vco_iv, 50);
        run_vco("R8");
        chk("R8 new period", vco_iv, 90);

        // R12: ratios 0 and 1
        measure_vco("R12 ratio 0", 16'd0);
        measure_vco("R12 ratio 1", 16'd1);

        // R11, R9, R10: phase detector
        div_word = 16'd180; ref_sel = 3'd0;
        reset_dut();
        repeat (360) step(1, 1);
        chk("R11 aligned up", up_cyc, 0);
        chk("R11 aligned dn", dn_cyc, 0);
        chk("R11 aligned pulses", ref_np + vco_np, 4);
        up_cyc = 0; dn_cyc = 0;
        step(1, 0);
        repeat (359) step(1, 1);
        step(0, 1);
        chk("R9 up width", up_cyc, 8);
        chk("R9 no dn", dn_cyc, 0);
        up_cyc = 0; dn_cyc = 0;
        step(0, 1);
        repeat (359) step(1, 1);
        step(1, 0);
        chk("R10 dn width", dn_cyc, 8);
        chk("R10 no up", up_cyc, 0);
        chk("R11 never both", both_cyc, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule